// File: doc/BRIEF.md
# Paged Program Memory Window

This block holds the instruction store for a set of sequencer engines and makes it reachable from a byte-wide register bus. The store keeps 96 sixteen-bit instructions in six pages of sixteen. A page register picks one page, and that page appears as a 32-byte window at bus addresses 0x50 to 0x6F. Each instruction takes two adjacent window bytes. The upper byte sits at the even offset and the lower byte at the odd offset. The even byte is held in a staging register. The whole instruction is committed to the store when the odd byte arrives.

Window writes are honoured only while at least one engine reports load mode and the busy flag is low. Writes that arrive at other times are dropped without any effect. Reads are never blocked.

A bus burst names an address only on its first byte. When the auto-step bit in the setup register is set, each later byte of the burst goes to the next address. The exception is the range 0x16 to 0x1E: inside it the address does not advance. A page write at 0x4F can therefore be followed directly by a full page of instruction bytes in one burst. A separate fetch port lets the engines read any instruction by its absolute index, with one cycle of latency.

Top module: `prog_mem_window`

## Requirements
- R1: After reset the page register reads 0, the setup register reads 0, every instruction is zero, and fetch_data is zero.
- R2: The page register at 0x4F takes a written value from 0 to 5 and reads it back in bits [2:0]. A write of 6 or more leaves it unchanged.
- R3: A read of window address 0x50+2k returns bits [15:8] of instruction page*16+k, and a read of 0x50+2k+1 returns bits [7:0] of that instruction. rd_data is combinational from rd_addr.
- R4: A write to an even window offset changes no stored instruction. The following odd-offset write commits {staged byte, written byte} to the instruction.
- R5: A window write is accepted only when eng_load has a bit set and eng_busy is low. Any other window write leaves every instruction unchanged.
- R6: Window reads return the stored contents whatever the state of eng_load and eng_busy.
- R7: The setup register at 0x0F holds the auto-step enable in bit 0. With that bit set, a write with bus_first low goes to the previous write address plus one.
- R8: With the auto-step enable clear, a write with bus_first low goes to the same address as the previous write.
- R9: When the previous write address lies in 0x16 to 0x1E, a write with bus_first low goes to that same address even when auto-step is set.
- R10: With fetch_en high at a clock edge, fetch_data shows instruction fetch_idx after that edge. With fetch_en low, fetch_data holds its value.
- R11: A fetch of an index of 96 or above returns zero.
- R12: Writes to the page register and the setup register are accepted whatever the state of eng_load and eng_busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe for one byte |
| bus_first | input | 1 | The write carries its own address (first byte of a burst) |
| bus_addr | input | 8 | Byte address, used when bus_first is high |
| bus_wdata | input | 8 | Write data byte |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data for rd_addr |
| eng_load | input | 3 | One bit per engine, high while that engine is in load mode |
| eng_busy | input | 1 | Busy flag; blocks window writes while high |
| fetch_en | input | 1 | Engine fetch request |
| fetch_idx | input | 7 | Absolute instruction index for a fetch |
| fetch_data | output | 16 | Fetched instruction, one cycle after the request |

## Verification
The bench fills all six pages with one auto-stepping burst per page. Each burst starts at the page register and runs on into the window, so a pointer that skipped the page byte or stepped by two would shift every instruction. A burst started inside the no-step range runs for more than 49 bytes. If the pointer leaked out of that range it would reach the page register and rewrite it, which the bench sees as a changed page. The bench also checks that a lone upper byte never shows up in a read or a fetch, and that writes made with busy set or with no engine loading leave the store intact. It writes page values of six and above and checks they are refused. It fetches indices past the top of the store, which a design with no range guard would answer with wrapped or stale words.

// File: rtl/pmw_pkg.sv
package pmw_pkg;

  typedef logic [7:0] pmw_byte_t;

  typedef enum logic [1:0] {
    PMW_SRC_NONE = 2'd0,
    PMW_SRC_PAGE = 2'd1,
    PMW_SRC_CFG  = 2'd2,
    PMW_SRC_WIN  = 2'd3
  } pmw_rd_src_e;

endpackage

// File: rtl/pmw_addr_seq.sv
module pmw_addr_seq #(
  parameter int                  ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]   NOINC_LO = 8'h16,
  parameter logic [ADDR_W-1:0]   NOINC_HI = 8'h1E
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bus_wr,
  input  logic              bus_first,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              autoinc_en,
  output logic [ADDR_W-1:0] eff_addr
);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              in_hold_range;

  assign eff_addr      = bus_first ? bus_addr : ptr_q;
  assign in_hold_range = (eff_addr >= NOINC_LO) && (eff_addr <= NOINC_HI);

  always_comb begin
    ptr_d = ptr_q;
    if (bus_wr) begin
      if (autoinc_en && !in_hold_range) ptr_d = eff_addr + ADDR_W'(1);
      else                              ptr_d = eff_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  AST_NOINC_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && in_hold_range) |=> (ptr_q == $past(eff_addr))); // R9
  AST_NO_STEP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && !autoinc_en) |=> (ptr_q == $past(eff_addr))); // R8
  AST_IDLE_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_ni)
    !bus_wr |=> $stable(ptr_q)); // R7

endmodule

// File: rtl/pmw_ctrl_regs.sv
module pmw_ctrl_regs #(
  parameter int                ADDR_W    = 8,
  parameter int                NUM_PAGES = 6,
  parameter int                NUM_ENG   = 3,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 8'h4F,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h0F,
  localparam int               PAGE_W    = $clog2(NUM_PAGES)
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  eff_addr,
  input  pmw_pkg::pmw_byte_t bus_wdata,
  input  logic [NUM_ENG-1:0] eng_load,
  input  logic               eng_busy,
  output logic [PAGE_W-1:0]  page_q,
  output logic               autoinc_q,
  output logic               gate_open
);

  logic [PAGE_W-1:0] page_d;
  logic              autoinc_d;
  logic              page_wr, page_ok, cfg_wr;

  assign page_wr   = bus_wr && (eff_addr == PAGE_ADDR);
  assign page_ok   = bus_wdata < pmw_pkg::pmw_byte_t'(NUM_PAGES);
  assign cfg_wr    = bus_wr && (eff_addr == CFG_ADDR);
  assign gate_open = (|eng_load) && !eng_busy;

  always_comb begin
    page_d    = page_q;
    autoinc_d = autoinc_q;
    if (page_wr && page_ok) page_d    = bus_wdata[PAGE_W-1:0];
    if (cfg_wr)             autoinc_d = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q    <= '0;
      autoinc_q <= 1'b0;
    end else begin
      page_q    <= page_d;
      autoinc_q <= autoinc_d;
    end
  end

  AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    (page_q < PAGE_W'(NUM_PAGES))); // R2
  AST_PAGE_IGNORE: assert property (@(posedge clk) disable iff (!rst_ni)
    (page_wr && !page_ok) |=> $stable(page_q)); // R2
  AST_PAGE_UNGATED: assert property (@(posedge clk) disable iff (!rst_ni)
    (page_wr && page_ok) |=> (page_q == $past(bus_wdata[PAGE_W-1:0]))); // R12

endmodule

// File: rtl/pmw_store.sv
module pmw_store #(
  parameter int                ADDR_W     = 8,
  parameter int                NUM_PAGES  = 6,
  parameter int                PAGE_WORDS = 16,
  parameter int                INSTR_W    = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 8'h50,
  localparam int               PAGE_W     = $clog2(NUM_PAGES),
  localparam int               DEPTH      = NUM_PAGES * PAGE_WORDS,
  localparam int               IDX_W      = $clog2(DEPTH),
  localparam int               WIN_BYTES  = 2 * PAGE_WORDS,
  localparam int               WOFF_W     = $clog2(WIN_BYTES),
  localparam int               HALF_W     = INSTR_W / 2
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  eff_addr,
  input  logic [HALF_W-1:0]  bus_wdata,
  input  logic               gate_open,
  input  logic [PAGE_W-1:0]  page,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_hit,
  output logic [HALF_W-1:0]  rd_byte,
  input  logic               fetch_en,
  input  logic [IDX_W-1:0]   fetch_idx,
  output logic [INSTR_W-1:0] fetch_data
);

  localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(int'(WIN_BASE) + WIN_BYTES - 1);

  logic [DEPTH-1:0][INSTR_W-1:0] mem_q;
  logic [DEPTH-1:0]              word_we;
  logic [HALF_W-1:0]             stage_q, stage_d;
  logic [INSTR_W-1:0]            fetch_d;
  logic                          wr_hit, wr_ok, commit;
  logic [WOFF_W-1:0]             wr_off, rd_off;
  logic [IDX_W-1:0]              wr_idx, rd_idx;
  logic [INSTR_W-1:0]            rd_word;

  // write side: window decode, gate, stage the even byte
  assign wr_hit = (eff_addr >= WIN_BASE) && (eff_addr <= WIN_END);
  assign wr_off = WOFF_W'(eff_addr - WIN_BASE);
  assign wr_ok  = bus_wr && wr_hit && gate_open;
  assign commit = wr_ok && wr_off[0];
  assign wr_idx = IDX_W'(page) * IDX_W'(PAGE_WORDS) + IDX_W'(wr_off[WOFF_W-1:1]);

  always_comb begin
    stage_d = stage_q;
    if (wr_ok && !wr_off[0]) stage_d = bus_wdata;
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_we
    assign word_we[gi] = commit && (wr_idx == IDX_W'(gi));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      mem_q   <= '0;
    end else begin
      stage_q <= stage_d;
      for (int i = 0; i < DEPTH; i++) begin
        if (word_we[i]) mem_q[i] <= {stage_q, bus_wdata};
      end
    end
  end

  // read side: window view of the selected page
  assign rd_hit  = (rd_addr >= WIN_BASE) && (rd_addr <= WIN_END);
  assign rd_off  = WOFF_W'(rd_addr - WIN_BASE);
  assign rd_idx  = IDX_W'(page) * IDX_W'(PAGE_WORDS) + IDX_W'(rd_off[WOFF_W-1:1]);
  assign rd_word = mem_q[rd_idx];
  assign rd_byte = rd_off[0] ? rd_word[HALF_W-1:0] : rd_word[INSTR_W-1:HALF_W];

  // engine fetch port
  always_comb begin
    fetch_d = fetch_data;
    if (fetch_en) fetch_d = (fetch_idx < IDX_W'(DEPTH)) ? mem_q[fetch_idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) fetch_data <= '0;
    else         fetch_data <= fetch_d;
  end

  AST_GATE_CLOSED_KEEPS: assert property (@(posedge clk) disable iff (!rst_ni)
    !gate_open |=> $stable(mem_q)); // R5
  AST_EVEN_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && wr_hit && !wr_off[0]) |=> $stable(mem_q)); // R4
  AST_FETCH_OOR: assert property (@(posedge clk) disable iff (!rst_ni)
    (fetch_en && (fetch_idx >= IDX_W'(DEPTH))) |=> (fetch_data == '0)); // R11
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !fetch_en |=> $stable(fetch_data)); // R10

endmodule

// File: rtl/prog_mem_window.sv
module prog_mem_window #(
  parameter int                ADDR_W     = 8,
  parameter int                NUM_PAGES  = 6,
  parameter int                PAGE_WORDS = 16,
  parameter int                INSTR_W    = 16,
  parameter int                NUM_ENG    = 3,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 8'h50,
  parameter logic [ADDR_W-1:0] PAGE_ADDR  = 8'h4F,
  parameter logic [ADDR_W-1:0] CFG_ADDR   = 8'h0F,
  parameter logic [ADDR_W-1:0] NOINC_LO   = 8'h16,
  parameter logic [ADDR_W-1:0] NOINC_HI   = 8'h1E,
  localparam int               PAGE_W     = $clog2(NUM_PAGES),
  localparam int               IDX_W      = $clog2(NUM_PAGES * PAGE_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_first,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [7:0]         bus_wdata,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [7:0]         rd_data,
  input  logic [NUM_ENG-1:0] eng_load,
  input  logic               eng_busy,
  input  logic               fetch_en,
  input  logic [IDX_W-1:0]   fetch_idx,
  output logic [INSTR_W-1:0] fetch_data
);

  import pmw_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] eff_addr;
  logic [PAGE_W-1:0] page_q;
  logic              autoinc_q, gate_open;
  logic              win_rd_hit;
  pmw_byte_t         win_rd_byte;
  pmw_rd_src_e       rd_src;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pmw_addr_seq #(
    .ADDR_W   (ADDR_W),
    .NOINC_LO (NOINC_LO),
    .NOINC_HI (NOINC_HI)
  ) u_addr_seq (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .bus_wr     (bus_wr),
    .bus_first  (bus_first),
    .bus_addr   (bus_addr),
    .autoinc_en (autoinc_q),
    .eff_addr   (eff_addr)
  );

  pmw_ctrl_regs #(
    .ADDR_W    (ADDR_W),
    .NUM_PAGES (NUM_PAGES),
    .NUM_ENG   (NUM_ENG),
    .PAGE_ADDR (PAGE_ADDR),
    .CFG_ADDR  (CFG_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rst_ni    (rst_int_n),
    .bus_wr    (bus_wr),
    .eff_addr  (eff_addr),
    .bus_wdata (bus_wdata),
    .eng_load  (eng_load),
    .eng_busy  (eng_busy),
    .page_q    (page_q),
    .autoinc_q (autoinc_q),
    .gate_open (gate_open)
  );

  pmw_store #(
    .ADDR_W     (ADDR_W),
    .NUM_PAGES  (NUM_PAGES),
    .PAGE_WORDS (PAGE_WORDS),
    .INSTR_W    (INSTR_W),
    .WIN_BASE   (WIN_BASE)
  ) u_store (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .bus_wr     (bus_wr),
    .eff_addr   (eff_addr),
    .bus_wdata  (bus_wdata),
    .gate_open  (gate_open),
    .page       (page_q),
    .rd_addr    (rd_addr),
    .rd_hit     (win_rd_hit),
    .rd_byte    (win_rd_byte),
    .fetch_en   (fetch_en),
    .fetch_idx  (fetch_idx),
    .fetch_data (fetch_data)
  );

  always_comb begin
    if (win_rd_hit)                rd_src = PMW_SRC_WIN;
    else if (rd_addr == PAGE_ADDR) rd_src = PMW_SRC_PAGE;
    else if (rd_addr == CFG_ADDR)  rd_src = PMW_SRC_CFG;
    else                           rd_src = PMW_SRC_NONE;
  end

  always_comb begin
    case (rd_src)
      PMW_SRC_WIN:  rd_data = win_rd_byte;
      PMW_SRC_PAGE: rd_data = pmw_byte_t'(page_q);
      PMW_SRC_CFG:  rd_data = pmw_byte_t'(autoinc_q);
      default:      rd_data = '0;
    endcase
  end

  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_addr == CFG_ADDR) |-> (rd_data[7:1] == 7'd0)); // R7
  AST_PAGE_READBACK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_addr == PAGE_ADDR) |-> (rd_data < 8'(NUM_PAGES))); // R2

endmodule

// File: tb/prog_mem_window_tb_top.sv
`timescale 1ns/1ps
module prog_mem_window_tb_top;

  localparam logic [7:0] PG  = 8'h4F;
  localparam logic [7:0] CFG = 8'h0F;
  localparam logic [7:0] WB  = 8'h50;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_first;
  logic [7:0]  bus_addr, bus_wdata, rd_addr, rd_data;
  logic [2:0]  eng_load;
  logic        eng_busy, fetch_en;
  logic [6:0]  fetch_idx;
  logic [15:0] fetch_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [15:0] exp_mem [96];

  always #2.5 clk = ~clk;

  prog_mem_window dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_first(bus_first),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .eng_load(eng_load), .eng_busy(eng_busy), .fetch_en(fetch_en),
    .fetch_idx(fetch_idx), .fetch_data(fetch_data)
  );

  function automatic logic [15:0] pat(input int i);
    return 16'((i * 16'h0137) ^ 16'hC35A);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input bit first, input logic [7:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_first = first; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_first = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic fetch(input int idx, output logic [15:0] d);
    fetch_en = 1'b1; fetch_idx = 7'(idx);
    @(negedge clk);
    fetch_en = 1'b0;
    d = fetch_data;
  endtask

  task automatic chk_word(input string req, input int p, input int k);
    logic [7:0] hi, lo;
    rd(WB + 8'(2*k), hi);
    rd(WB + 8'(2*k+1), lo);
    chk(req, {hi, lo}, exp_mem[p*16+k]);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    rst_n = 1'b0; bus_wr = 0; bus_first = 0; bus_addr = 0; bus_wdata = 0;
    rd_addr = 0; eng_load = 0; eng_busy = 0; fetch_en = 0; fetch_idx = 0;
    for (int i = 0; i < 96; i++) exp_mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 fetch_data after reset", fetch_data, 16'h0);
    rd(PG, b);  chk("R1 page after reset", b, 8'h0);
    rd(CFG, b); chk("R1 setup after reset", b, 8'h0);
    for (int i = 0; i < 96; i++) begin
      fetch(i, w); chk("R1 instruction zero after reset", w, 16'h0);
    end

    // R7 enable auto-step, fill every page with one burst per page
    eng_load = 3'b010; eng_busy = 1'b0;
    wr(1, CFG, 8'h01);
    rd(CFG, b); chk("R7 setup readback", b, 8'h01);
    for (int p = 0; p < 6; p++) begin
      wr(1, PG, 8'(p));
      for (int k = 0; k < 16; k++) begin
        w = pat(p*16+k);
        wr(0, 8'h00, w[15:8]);
        wr(0, 8'h00, w[7:0]);
        exp_mem[p*16+k] = w;
      end
    end

    // R3 window readback of every page, R2 page readback
    for (int p = 0; p < 6; p++) begin
      wr(1, PG, 8'(p));
      rd(PG, b); chk("R2 page readback", b, 8'(p));
      for (int k = 0; k < 16; k++) chk_word("R3 R7 window word after burst", p, k);
    end

    // R10 R11 fetch sweep including out-of-range indices
    for (int i = 0; i < 128; i++) begin
      fetch(i, w);
      if (i < 96) chk("R10 fetch by absolute index", w, exp_mem[i]);
      else        chk("R11 fetch beyond store", w, 16'h0);
    end
    fetch_idx = 7'd5;
    repeat (2) @(negedge clk);
    chk("R10 fetch_data holds when idle", fetch_data, 16'h0);

    // R2 invalid page values are refused
    wr(1, PG, 8'd3);
    wr(1, PG, 8'd6);  rd(PG, b); chk("R2 page 6 ignored", b, 8'd3);
    wr(1, PG, 8'd7);  rd(PG, b); chk("R2 page 7 ignored", b, 8'd3);
    wr(1, PG, 8'hFF); rd(PG, b); chk("R2 page FF ignored", b, 8'd3);

    // R5 gate closed by busy, R6 reads still work, R12 page write ungated
    eng_busy = 1'b1;
    wr(1, WB, 8'h11); wr(0, 8'h00, 8'h22); wr(0, 8'h00, 8'h33); wr(0, 8'h00, 8'h44);
    chk_word("R5 R6 busy blocks write, word0 read", 3, 0);
    chk_word("R5 R6 busy blocks write, word1 read", 3, 1);
    wr(1, PG, 8'd4); rd(PG, b); chk("R12 page write while busy", b, 8'd4);
    chk_word("R6 read while busy", 4, 7);
    // R5 gate closed by no engine in load mode
    eng_busy = 1'b0; eng_load = 3'b000;
    wr(1, WB, 8'h55); wr(0, 8'h00, 8'h66);
    chk_word("R5 no load blocks write", 4, 0);
    wr(1, CFG, 8'h00); rd(CFG, b); chk("R12 setup write with no load", b, 8'h00);
    wr(1, CFG, 8'h01);

    // R4 even byte alone commits nothing
    eng_load = 3'b100;
    wr(1, PG, 8'd0);
    wr(1, WB + 8'd2, 8'hAB);
    chk_word("R4 even byte alone no commit", 0, 1);
    fetch(1, w); chk("R4 fetch after even byte alone", w, exp_mem[1]);
    wr(1, WB + 8'd3, 8'hCD);
    exp_mem[1] = 16'hABCD;
    chk_word("R4 odd byte commits staged pair", 0, 1);

    // R8 auto-step off: continuation repeats the address
    wr(1, CFG, 8'h00);
    wr(1, WB + 8'd4, 8'h12);
    wr(0, 8'h00, 8'h34);
    chk_word("R8 repeat even address no commit", 0, 2);
    wr(1, WB + 8'd5, 8'h56);
    exp_mem[2] = 16'h3456;
    chk_word("R8 continuation hit same address", 0, 2);

    // R9 no-step range holds the pointer
    wr(1, CFG, 8'h01);
    wr(1, 8'h1E, 8'h03);
    for (int j = 0; j < 60; j++) wr(0, 8'h00, 8'h03);
    rd(PG, b); chk("R9 pointer stuck at range top", b, 8'd0);
    chk_word("R9 window untouched from range top", 0, 0);
    wr(1, 8'h15, 8'h02);
    for (int j = 0; j < 60; j++) wr(0, 8'h00, 8'h02);
    rd(PG, b); chk("R9 pointer stuck after entering range", b, 8'd0);
    chk_word("R9 window untouched after entering range", 0, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule